// File: doc/BRIEF.md
# Pixel Clock Parameter Search Engine

This block finds the clock-generator setting whose output lands closest to a requested pixel frequency. After a one-cycle `start`, it walks every legal combination of source frequency, odd divider and power-of-two shift. For each combination it forms a rounded quotient with a shared restoring divider and measures the absolute error against the target. It keeps the best combination found so far.

The source is one of two built-in frequencies, 288 MHz and 336 MHz. If a nonzero fixed source frequency is supplied, only that source is searched. The odd divider set depends on the display type, and the shift runs over 0 to 7. At the end the engine reports the winning source, divider code and shift. It also makes one more division pass to report the truncated output frequency of that setting, then pulses `done`.

`start`, `busy` and `done` are plain control and status pins with no valid/ready handshake. Inputs are captured when a start is accepted, and the results hold their values until the next search finishes. All frequencies are unsigned integers in Hz.

Top module: `pixclk_search`

## Requirements
- R1: With `fixed_src_hz` equal to zero, the reported source is always 288000000 or 336000000, and both are searched, 288000000 first.
- R2: The divider code maps to an odd divider as code 0 = 1, code 1 = 3 and code 2 = 5. Codes 0 and 1 are tried when `is_panel` is 0, and code 2 is tried only when `is_panel` is 1.
- R3: Shifts 0 to 7 are all tried, and the effective divisor is divider << shift. The search order is source outermost, then divider code ascending, then shift ascending as the innermost loop.
- R4: The candidate frequency is the rounded quotient (2·src + d) / (2·d), where d is the effective divisor, and its error is |quotient − target|.
- R5: A candidate replaces the stored best only when its error is strictly smaller, so on equal error the earlier candidate in the R3 order is kept.
- R6: With a nonzero `fixed_src_hz`, that value is the only source searched and reported.
- R7: `res_hz` equals src / (divider << shift) with truncating division for the chosen setting, not the rounded value.
- R8: The best error starts at 999999999. If no candidate beats it, the first candidate of the order is reported, which is divider code 0 and shift 0 on the first source.
- R9: `done` is high for exactly one cycle per search, and `busy` is high from the cycle after an accepted start until `done`. A `start` while `busy` is ignored and does not change the result of the search in progress.
- R10: After reset, `busy`, `done` and all result outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a search. Sampled only when idle |
| target_hz | input | FW | Requested pixel frequency in Hz |
| is_panel | input | 1 | 1 = panel (also tries divider 5), 0 = CRT |
| fixed_src_hz | input | FW | Fixed source frequency. 0 selects the two built-in sources |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse when the results are updated |
| res_src_hz | output | FW | Chosen source frequency |
| res_div_code | output | 2 | Chosen divider code (0=1, 1=3, 2=5) |
| res_shift | output | SHW | Chosen shift |
| res_hz | output | FW | Truncated output frequency of the chosen setting |

## Verification
Each candidate takes W+2 cycles, where W = FW+2 is the divider width: one cycle to launch the divider, W cycles of iteration and one cycle that consumes the quotient. The final truncating pass costs the same again, and `done` then follows on the next edge. A search with N candidates therefore finishes about (N+1)·(W+2)+1 cycles after the edge that samples `start`. The bench does not assume that count. It polls `done` on falling edges under a timeout, samples every result in the cycle where `done` is seen, and confirms one falling edge later that `done` has dropped.

// File: rtl/pixclk_pkg.sv
package pixclk_pkg;
  localparam logic [31:0] SRC_LO   = 32'd288000000;
  localparam logic [31:0] SRC_HI   = 32'd336000000;
  localparam logic [31:0] ERR_INIT = 32'd999999999;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LAUNCH,
    ST_WAIT,
    ST_FLAUNCH,
    ST_FWAIT
  } pcs_state_e;
endpackage

// File: rtl/pixclk_rdiv.sv
module pixclk_rdiv #(
  parameter int W = 34
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         rdy,
  output logic [W-1:0] quo
);
  localparam int CW = $clog2(W);

  logic [W-1:0]  rem_q, den_q, num_q, qsh_q;
  logic [CW-1:0] cnt_q;
  logic          act_q;
  logic [W:0]    trial;
  logic          ge;

  assign trial = {rem_q, qsh_q[W-1]};
  assign ge    = trial >= {1'b0, den_q};
  assign quo   = qsh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0; den_q <= '0; num_q <= '0; qsh_q <= '0;
      cnt_q <= '0; act_q <= 1'b0; rdy <= 1'b0;
    end else begin
      rdy <= 1'b0;
      if (go) begin
        rem_q <= '0;
        qsh_q <= num;
        num_q <= num;
        den_q <= den;
        cnt_q <= CW'(W-1);
        act_q <= 1'b1;
      end else if (act_q) begin
        rem_q <= ge ? W'(trial - {1'b0, den_q}) : W'(trial);
        qsh_q <= {qsh_q[W-2:0], ge};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == '0) begin
          act_q <= 1'b0;
          rdy   <= 1'b1;
        end
      end
    end
  end

  // Quotient check: q*d <= n < (q+1)*d
  logic [2*W-1:0] prod_lo, prod_hi;
  assign prod_lo = {{W{1'b0}}, qsh_q} * {{W{1'b0}}, den_q};
  assign prod_hi = prod_lo + {{W{1'b0}}, den_q};

  p_quot_exact_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rdy |-> (prod_lo <= {{W{1'b0}}, num_q}) && (prod_hi > {{W{1'b0}}, num_q}));
endmodule

// File: rtl/pixclk_best.sv
module pixclk_best #(
  parameter int FW  = 32,
  parameter int SHW = 3,
  parameter int W   = 34
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clr,
  input  logic [FW-1:0]  init_src,
  input  logic           upd,
  input  logic [FW-1:0]  c_src,
  input  logic [1:0]     c_div,
  input  logic [SHW-1:0] c_sh,
  input  logic [W-1:0]   c_err,
  output logic [FW-1:0]  b_src,
  output logic [1:0]     b_div,
  output logic [SHW-1:0] b_sh
);
  import pixclk_pkg::*;

  logic [W-1:0] b_err;
  logic         take;

  assign take = upd && (c_err < b_err);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_src <= '0; b_div <= '0; b_sh <= '0; b_err <= W'(ERR_INIT);
    end else if (clr) begin
      b_src <= init_src; b_div <= '0; b_sh <= '0; b_err <= W'(ERR_INIT);
    end else if (take) begin
      b_src <= c_src; b_div <= c_div; b_sh <= c_sh; b_err <= c_err;
    end
  end

  p_err_nonincr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !clr) |=> (b_err <= $past(b_err)));

  p_tie_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && !clr && (c_err >= b_err)) |=> ($stable(b_src) && $stable(b_div) && $stable(b_sh)));
endmodule

// File: rtl/pixclk_search.sv
module pixclk_search
  import pixclk_pkg::*;
#(
  parameter int FW  = 32,
  parameter int SHW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [FW-1:0]  target_hz,
  input  logic           is_panel,
  input  logic [FW-1:0]  fixed_src_hz,
  output logic           busy,
  output logic           done,
  output logic [FW-1:0]  res_src_hz,
  output logic [1:0]     res_div_code,
  output logic [SHW-1:0] res_shift,
  output logic [FW-1:0]  res_hz
);
  localparam int W = FW + 2;
  localparam logic [SHW-1:0] SH_MAX = '1;

  pcs_state_e     st;
  logic [FW-1:0]  tgt_q, fix_q;
  logic           pan_q, src_sel;
  logic [1:0]     dcode;
  logic [SHW-1:0] sh;

  logic [FW-1:0]  cur_src, best_src, init_src;
  logic [1:0]     best_div, last_div;
  logic [SHW-1:0] best_sh;
  logic [W-1:0]   dvs, num, den, quo, err, tgt_w;
  logic           div_go, rdy, upd, last, clr;

  assign cur_src  = (fix_q != '0) ? fix_q : (src_sel ? FW'(SRC_HI) : FW'(SRC_LO));
  assign init_src = (fixed_src_hz != '0) ? fixed_src_hz : FW'(SRC_LO);
  assign dvs      = W'({dcode, 1'b1}) << sh;
  assign last_div = pan_q ? 2'd2 : 2'd1;
  assign last     = (sh == SH_MAX) && (dcode == last_div) && ((fix_q != '0) || src_sel);
  assign div_go   = (st == ST_LAUNCH) || (st == ST_FLAUNCH);
  assign clr      = (st == ST_IDLE) && start;
  assign upd      = (st == ST_WAIT) && rdy;
  assign busy     = (st != ST_IDLE);
  assign tgt_w    = W'(tgt_q);
  assign err      = (quo >= tgt_w) ? quo - tgt_w : tgt_w - quo;

  always_comb begin
    if (st == ST_FLAUNCH) begin
      num = W'(best_src);
      den = W'({best_div, 1'b1}) << best_sh;
    end else begin
      num = (W'(cur_src) << 1) + dvs;
      den = dvs << 1;
    end
  end

  pixclk_rdiv #(.W(W)) u_div (
    .clk(clk), .rst_n(rst_n), .go(div_go), .num(num), .den(den),
    .rdy(rdy), .quo(quo)
  );

  pixclk_best #(.FW(FW), .SHW(SHW), .W(W)) u_best (
    .clk(clk), .rst_n(rst_n), .clr(clr), .init_src(init_src), .upd(upd),
    .c_src(cur_src), .c_div(dcode), .c_sh(sh), .c_err(err),
    .b_src(best_src), .b_div(best_div), .b_sh(best_sh)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; tgt_q <= '0; fix_q <= '0; pan_q <= 1'b0;
      src_sel <= 1'b0; dcode <= '0; sh <= '0; done <= 1'b0;
      res_src_hz <= '0; res_div_code <= '0; res_shift <= '0; res_hz <= '0;
    end else begin
      done <= 1'b0;
      unique case (st)
        ST_IDLE: if (start) begin
          tgt_q <= target_hz; fix_q <= fixed_src_hz; pan_q <= is_panel;
          src_sel <= 1'b0; dcode <= '0; sh <= '0;
          st <= ST_LAUNCH;
        end
        ST_LAUNCH: st <= ST_WAIT;
        ST_WAIT: if (rdy) begin
          if (last) st <= ST_FLAUNCH;
          else begin
            st <= ST_LAUNCH;
            if (sh != SH_MAX) sh <= sh + 1'b1;
            else begin
              sh <= '0;
              if (dcode != last_div) dcode <= dcode + 1'b1;
              else begin
                dcode   <= '0;
                src_sel <= 1'b1;
              end
            end
          end
        end
        ST_FLAUNCH: st <= ST_FWAIT;
        ST_FWAIT: if (rdy) begin
          res_src_hz   <= best_src;
          res_div_code <= best_div;
          res_shift    <= best_sh;
          res_hz       <= quo[FW-1:0];
          done         <= 1'b1;
          st           <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_div_allowed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !pan_q) |-> (res_div_code != 2'd2));

  p_src_pair_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (fix_q == '0)) |-> ((res_src_hz == FW'(SRC_LO)) || (res_src_hz == FW'(SRC_HI))));

  p_fixed_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (fix_q != '0)) |-> (res_src_hz == fix_q));
endmodule

// File: tb/sim_pixclk_search.sv
`timescale 1ns/1ps
module sim_pixclk_search;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] target_hz = '0;
  logic        is_panel = 1'b0;
  logic [31:0] fixed_src_hz = '0;
  logic        busy, done;
  logic [31:0] res_src_hz, res_hz;
  logic [1:0]  res_div_code;
  logic [2:0]  res_shift;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  pixclk_search u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .target_hz(target_hz),
    .is_panel(is_panel), .fixed_src_hz(fixed_src_hz), .busy(busy), .done(done),
    .res_src_hz(res_src_hz), .res_div_code(res_div_code), .res_shift(res_shift),
    .res_hz(res_hz)
  );

  typedef struct packed {
    logic [31:0] tgt;
    logic        pan;
    logic [31:0] fix;
    logic [31:0] e_src;
    logic [1:0]  e_div;
    logic [2:0]  e_sh;
    logic [31:0] e_hz;
  } vec_t;

  // 0: R1/R3 exact on 288/2; 1: R1 second source, div 3; 2: R2 panel div 5;
  // 3: R2 CRT lacks div 5; 4: R5 tie keeps shift 0; 5: R4 rounding + R7 truncation;
  // 6: R8 nothing beats initial error.
  localparam vec_t VT [7] = '{
    '{32'd144000000, 1'b0, 32'd0,         32'd288000000, 2'd0, 3'd1, 32'd144000000},
    '{32'd112000000, 1'b0, 32'd0,         32'd336000000, 2'd1, 3'd0, 32'd112000000},
    '{32'd57600000,  1'b1, 32'd0,         32'd288000000, 2'd2, 3'd0, 32'd57600000},
    '{32'd57600000,  1'b0, 32'd0,         32'd336000000, 2'd1, 3'd1, 32'd56000000},
    '{32'd75000000,  1'b0, 32'd100000000, 32'd100000000, 2'd0, 3'd0, 32'd100000000},
    '{32'd2,         1'b0, 32'd7,         32'd7,         2'd0, 3'd2, 32'd1},
    '{32'hFFFFFFFF,  1'b0, 32'd0,         32'd288000000, 2'd0, 3'd0, 32'd288000000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic launch(input vec_t v);
    @(negedge clk);
    target_hz = v.tgt; is_panel = v.pan; fixed_src_hz = v.fix; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output logic ok);
    ok = 1'b0;
    for (int i = 0; i < 5000; i++) begin
      if (done) begin ok = 1'b1; break; end
      @(negedge clk);
    end
    if (!ok) chk("R9 done timeout", 32'd0, 32'd1);
  endtask

  task automatic check_result(input vec_t v, input string tag);
    chk({tag, " R1/R6 src"}, res_src_hz, v.e_src);
    chk({tag, " R2 div code"}, 32'(res_div_code), 32'(v.e_div));
    chk({tag, " R3 shift"}, 32'(res_shift), 32'(v.e_sh));
    chk({tag, " R7 res_hz"}, res_hz, v.e_hz);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk("watchdog", 32'd0, 32'd1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic ok;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 busy", 32'(busy), 32'd0);
    chk("R10 done", 32'(done), 32'd0);
    chk("R10 res_hz", res_hz, 32'd0);
    chk("R10 res_src", res_src_hz, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < 7; k++) begin
      launch(VT[k]);
      chk($sformatf("vec%0d R9 busy", k), 32'(busy), 32'd1);
      wait_done(ok);
      if (ok) begin
        check_result(VT[k], $sformatf("vec%0d", k));
        @(negedge clk);
        chk($sformatf("vec%0d R9 done one cycle", k), 32'(done), 32'd0);
        chk($sformatf("vec%0d R9 idle after", k), 32'(busy), 32'd0);
      end
    end

    // R9: start while busy is ignored
    launch(VT[0]);
    repeat (50) @(negedge clk);
    target_hz = VT[1].tgt; is_panel = 1'b1; fixed_src_hz = 32'd7; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(ok);
    if (ok) begin
      check_result(VT[0], "R9 start ignored");
      @(negedge clk);
      chk("R9 no second search", 32'(busy), 32'd0);
      repeat (60) @(negedge clk);
      chk("R9 no late done", 32'(done), 32'd0);
      chk("R9 result held", res_hz, VT[0].e_hz);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule